// File: doc/BRIEF.md
# Coding Violation Rate Monitor

This block gives a coarse verdict on the health of a received line. It counts the one-cycle coding-violation pulses that the line decoder raises, inside a measurement window. The length of the window is set by a slow, rate-dependent time-base clock, not by the line clock. The time-base clock is brought into the line-clock domain by a synchronizer. Its rising edges are counted as ticks, and every `WINDOW_TICKS` ticks close one window.

At each window boundary the number of violations in the closing window is compared with a threshold that matches an error rate of one in a million. The rate-select input chooses between the threshold for the high line rate and the one for the low line rate. The quality flag is registered at the boundary and keeps that verdict for the whole next window. It has meaning only when the correct time-base clock is supplied. While the rail-bypass mode is selected, the decoder is not in the path, so the flag is forced low.

With the default parameters the window is 60000 ticks. A 6 kHz time base gives a 10 s window, and a 1.5 kHz time base gives a 40 s window. The threshold is 344 violations for the high rate and 338 for the low rate.

Top module: `cv_rate_monitor`

## Requirements
- R1: A synchronous active-low reset drives `quality_bad` low, clears the violation count and clears the tick count, so that the first window starts at reset release.
- R2: A window closes on the `WINDOW_TICKS`-th rising edge of `tbase_clk` after the previous boundary. Falling edges do not advance the window, and fewer rising edges do not close it.
- R3: At a boundary, `quality_bad` becomes 1 when the window's violation count is strictly greater than the selected threshold. It becomes 0 when the count is equal to or below the threshold.
- R4: When `rate_low` is 0 the threshold is `THR_HIGH_RATE`, and when `rate_low` is 1 the threshold is `THR_LOW_RATE`. The value used is the one on `rate_low` in the boundary cycle.
- R5: Between boundaries, and while bypass is off, `quality_bad` keeps the value it took at the last boundary.
- R6: The violation count saturates at its all-ones value and never wraps. The counter width is chosen so that the all-ones value exceeds both thresholds.
- R7: A violation pulse in the same cycle as a boundary counts toward the window that is closing. It is not carried into the new window.
- R8: While `bypass_mode` is 1, `quality_bad` is 0 from the next clock edge on. After `bypass_mode` returns to 0, the flag stays 0 until the next boundary gives a verdict.
- R9: The violation count restarts from zero at every boundary, so the verdict of each window depends only on the pulses inside that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cv_pulse | input | 1 | One-cycle pulse per detected coding violation |
| tbase_clk | input | 1 | Slow time-base clock, asynchronous to `clk` |
| rate_low | input | 1 | 0 selects the high-rate threshold, 1 selects the low-rate threshold |
| bypass_mode | input | 1 | 1 while the rail-bypass mode is selected; forces the flag low |
| quality_bad | output | 1 | 1 when the last window exceeded the error threshold |

## Verification
A violation pulse can land in the same line-clock cycle as the synchronized tick that closes a window. In that cycle the counter has to add the pulse to the verdict and also clear itself. The bench raises the time-base clock and drives the violation pulse exactly two line-clock edges later. At that point the synchronizer presents the boundary tick. The closing window holds the threshold count plus this one pulse, so the expected flag is high. The next window holds exactly the threshold count, so the expected flag is low. A lost pulse shows up in the first verdict, and a pulse carried over shows up in the second.

// File: rtl/cvq_pkg.sv
// Package: shared helpers for the coding violation rate monitor.
// Assumes: thresholds are non-negative and fit in 32 bits.
package cvq_pkg;

    // Line-rate selection as driven on the rate input.
    typedef enum logic {
        CVQ_RATE_HIGH = 1'b0,
        CVQ_RATE_LOW  = 1'b1
    } cvq_rate_e;

    // Width of a counter whose all-ones value lies above both thresholds.
    function automatic int unsigned cvq_count_width(input int unsigned thr_a,
                                                    input int unsigned thr_b);
        int unsigned top;
        top = (thr_a > thr_b) ? thr_a : thr_b;
        return $clog2(top + 2);
    endfunction

endpackage

// File: rtl/cvq_tick_sync.sv
// Module: cvq_tick_sync
// Brings the slow time-base clock into the line-clock domain and emits a
// one-cycle tick for each rising edge it sees.
// Assumes: the time-base clock stays high and low for at least two line-clock
// cycles each, so that no edge is lost.
module cvq_tick_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tbase_clk,
    output logic tick_o
);
    localparam int unsigned LAST = SYNC_STAGES;

    logic [LAST:0] shift_q;

    // Shift the asynchronous level through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[LAST-1:0], tbase_clk};
        end
    end

    // A rising edge is a synchronized high after a synchronized low.
    always_comb begin
        tick_o = shift_q[LAST-1] & ~shift_q[LAST];
    end

endmodule

// File: rtl/cvq_window_timer.sv
// Module: cvq_window_timer
// Counts time-base ticks and pulses boundary_o in the cycle of the tick that
// completes a window of WINDOW_TICKS ticks.
// Assumes: tick_i is a one-cycle pulse; WINDOW_TICKS is at least 2.
module cvq_window_timer #(
    parameter int unsigned WINDOW_TICKS = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic boundary_o
);
    localparam int unsigned TW = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(WINDOW_TICKS - 1);

    logic [TW-1:0] ticks_q;
    logic          at_last;

    // Decode the final tick position of the window.
    always_comb begin
        at_last    = (ticks_q == LAST_TICK);
        boundary_o = tick_i & at_last;
    end

    // Advance on every tick and wrap to zero at the window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else if (tick_i) begin
            ticks_q <= at_last ? '0 : ticks_q + 1'b1;
        end
    end

endmodule

// File: rtl/cvq_event_counter.sv
// Module: cvq_event_counter
// Saturating counter of violation pulses. closing_o is the count that includes
// a pulse in the current cycle; it is the value judged at a boundary.
// Assumes: clear_i is the window boundary pulse.
module cvq_event_counter #(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          event_i,
    input  logic          clear_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] closing_o
);
    localparam logic [CW-1:0] FULL = '1;

    logic [CW-1:0] count_q;

    // Add the current pulse unless the count already sits at its ceiling.
    always_comb begin
        closing_o = (event_i && (count_q != FULL)) ? count_q + 1'b1 : count_q;
        count_o   = count_q;
    end

    // Hold the running total; restart from zero at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else begin
            count_q <= closing_o;
        end
    end

endmodule

// File: rtl/cv_rate_monitor.sv
// Module: cv_rate_monitor (top)
// Judges line quality once per window: flags when the violation count of the
// window exceeds the threshold of the selected line rate.
// Assumes: cv_pulse is synchronous to clk; tbase_clk is slow and asynchronous.
module cv_rate_monitor #(
    parameter int unsigned WINDOW_TICKS  = 60000,
    parameter int unsigned THR_HIGH_RATE = 344,
    parameter int unsigned THR_LOW_RATE  = 338,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cv_pulse,
    input  logic tbase_clk,
    input  logic rate_low,
    input  logic bypass_mode,
    output logic quality_bad
);
    import cvq_pkg::*;

    localparam int unsigned CW = cvq_count_width(THR_HIGH_RATE, THR_LOW_RATE);
    localparam logic [CW-1:0] THR_HI_C = CW'(THR_HIGH_RATE);
    localparam logic [CW-1:0] THR_LO_C = CW'(THR_LOW_RATE);

    logic          tick;
    logic          win_end;
    logic [CW-1:0] run_count;
    logic [CW-1:0] closing_count;
    logic [CW-1:0] thr_sel;
    logic          over_limit;
    logic          flag_q;
    cvq_rate_e     rate_sel;

    cvq_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbase_clk (tbase_clk),
        .tick_o    (tick)
    );

    cvq_window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .boundary_o (win_end)
    );

    cvq_event_counter #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (cv_pulse),
        .clear_i   (win_end),
        .count_o   (run_count),
        .closing_o (closing_count)
    );

    // Pick the threshold for the line rate and compare the closing count.
    always_comb begin
        rate_sel   = cvq_rate_e'(rate_low);
        thr_sel    = (rate_sel == CVQ_RATE_LOW) ? THR_LO_C : THR_HI_C;
        over_limit = closing_count > thr_sel;
    end

    // Register the verdict at boundaries; bypass forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (bypass_mode) begin
            flag_q <= 1'b0;
        end else if (win_end) begin
            flag_q <= over_limit;
        end
    end

    assign quality_bad = flag_q;

endmodule

// File: rtl/cvq_checker.sv
// Module: cvq_checker
// Temporal properties of the rate monitor, attached to the top by bind.
// Assumes: signals are sampled on the line clock with synchronous reset.
module cvq_checker #(
    parameter int unsigned CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          win_end,
    input logic          bypass_mode,
    input logic          quality_bad,
    input logic [CW-1:0] run_count
);
    localparam logic [CW-1:0] FULL = '1;

    // R2: a boundary can only occur on a synchronized tick.
    p_boundary_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> tick);

    // R3: the flag only rises as the result of a boundary.
    p_rise_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quality_bad) |-> $past(win_end));

    // R5: outside boundaries and bypass the flag holds.
    p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && !bypass_mode) |=> $stable(quality_bad));

    // R6: a full count stays full until the window closes.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_count == FULL && !win_end) |=> (run_count == FULL));

    // R8: bypass drives the flag low on the next edge.
    p_bypass_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_mode |=> !quality_bad);

    // R9: the count restarts from zero after each boundary.
    p_clear_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (run_count == '0));

endmodule

bind cv_rate_monitor cvq_checker #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .win_end     (win_end),
    .bypass_mode (bypass_mode),
    .quality_bad (quality_bad),
    .run_count   (run_count)
);

// File: tb/cv_rate_monitor_tb.sv
// Directed bench for cv_rate_monitor with a short window and small thresholds.
module cv_rate_monitor_tb;
    localparam int unsigned WIN = 4;
    localparam int unsigned THR_HI = 5;
    localparam int unsigned THR_LO = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cv_pulse = 1'b0;
    logic tbase_clk = 1'b0;
    logic rate_low = 1'b0;
    logic bypass_mode = 1'b0;
    logic quality_bad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cv_rate_monitor #(
        .WINDOW_TICKS  (WIN),
        .THR_HIGH_RATE (THR_HI),
        .THR_LOW_RATE  (THR_LO)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cv_pulse    (cv_pulse),
        .tbase_clk   (tbase_clk),
        .rate_low    (rate_low),
        .bypass_mode (bypass_mode),
        .quality_bad (quality_bad)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic exp);
        checks++;
        if (quality_bad !== exp) begin
            errors++;
            $display("FAIL %s: quality_bad=%b expected %b at %0t", req, quality_bad, exp, $time);
        end
    endtask

    // One full time-base period: rising edge, then falling edge.
    task automatic tb_tick();
        @(negedge clk) tbase_clk = 1'b1;
        repeat (4) @(negedge clk);
        tbase_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cv_pulse = 1'b1;
            @(negedge clk) cv_pulse = 1'b0;
        end
    endtask

    task automatic window(input int n);
        pulses(n);
        for (int i = 0; i < WIN; i++) tb_tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0);
    endtask

    task automatic t_threshold();
        window(THR_HI);
        check("R3 count equal to threshold", 1'b0);
        window(THR_HI + 1);
        check("R3 count above threshold", 1'b1);
    endtask

    task automatic t_hold_and_clear();
        tb_tick(); tb_tick();
        check("R5 flag held mid window", 1'b1);
        tb_tick(); tb_tick();
        check("R9 empty window after bad one", 1'b0);
    endtask

    task automatic t_rate();
        rate_low = 1'b1;
        window(THR_LO + 1);
        check("R4 low rate above threshold", 1'b1);
        window(THR_LO);
        check("R4 low rate at threshold", 1'b0);
        rate_low = 1'b0;
        window(THR_LO + 1);
        check("R4 high rate same count", 1'b0);
    endtask

    task automatic t_window_length();
        pulses(THR_HI + 1);
        for (int i = 0; i < WIN - 1; i++) tb_tick();
        check("R2 no verdict before last tick", 1'b0);
        tb_tick();
        check("R2 verdict on last tick", 1'b1);
    endtask

    task automatic t_saturation();
        window(9);
        check("R6 saturated count still above", 1'b1);
    endtask

    task automatic t_bypass();
        @(negedge clk) bypass_mode = 1'b1;
        @(negedge clk);
        check("R8 flag low next edge", 1'b0);
        window(9);
        check("R8 flag low during bypass", 1'b0);
        @(negedge clk) bypass_mode = 1'b0;
        pulses(THR_HI + 1);
        tb_tick(); tb_tick();
        check("R8 low after release until boundary", 1'b0);
        tb_tick(); tb_tick();
        check("R8 verdict after release", 1'b1);
    endtask

    task automatic t_coincide();
        pulses(THR_HI);
        for (int i = 0; i < WIN - 1; i++) tb_tick();
        @(negedge clk) tbase_clk = 1'b1;
        @(negedge clk);
        @(negedge clk) cv_pulse = 1'b1;
        @(negedge clk) cv_pulse = 1'b0;
        @(negedge clk) tbase_clk = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 boundary pulse counted in closing window", 1'b1);
        window(THR_HI);
        check("R7 boundary pulse not carried over", 1'b0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_hold_and_clear();
        t_rate();
        t_window_length();
        t_saturation();
        t_bypass();
        t_coincide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule